// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a small signal-processing engine. It works on 16-bit signed fractions, where 0x8000 stands for -1 and 0x7FFF is the largest positive value, so every value lies in [-1, 1). It holds two operand registers, X and Y, and a 32-bit product register. A multiplication is not a separate command. Any write into X or Y forms a new fractional product from the current contents of both registers. A paired write of X and Y can either replace the product or add the new product to the one already held, which gives a multiply-accumulate in a single cycle.

A 40-bit accumulator sits beside the product. It is made of 8 guard bits above a 32-bit high/low pair, so a long run of sums can grow past the 32-bit range without wrapping at once. An ALU adds or subtracts either the product or a 32-bit operand into the accumulator, and it can load the accumulator from either source. It also applies arithmetic and logical shifts, flips one chosen bit, and limits the accumulator back to the 32-bit range.

The surrounding engine drives one operation per cycle through a 4-bit opcode with a valid strobe. Instruction decode, memory and address generation stay outside this block.

Top module: `qmac_unit`

## Requirements
- R1: After reset the X, Y, product and accumulator registers all read zero.
- R2: Opcode 3 writes opnd_a into X and opnd_b into Y, and it replaces the product with their fractional product: the 32-bit signed product of the two operands shifted left by one.
- R3: When both operands of a multiplication equal 0x8000 (-1 × -1), the product becomes 0x7FFFFFFF and does not wrap to 0x80000000.
- R4: Opcode 1 writes opnd_a into X and opcode 2 writes opnd_a into Y. Each forms a new product from the newly written value and the value still held in the other register.
- R5: Opcode 4 writes X and Y as opcode 3 does, but the new product is the sum of the previous product and the new fractional product, saturated to the range 0x80000000..0x7FFFFFFF.
- R6: Opcode 5 adds the product and opcode 6 subtracts it. In both cases the product is sign-extended to 40 bits, and the accumulator wraps modulo 2^40.
- R7: Opcodes 7 and 8 add and subtract the sign-extended 32-bit operand wide_in to and from the accumulator. Opcode 9 loads the sign-extended product into the accumulator, and opcode 10 loads the sign-extended wide_in.
- R8: Opcode 11 shifts the accumulator right by sel_in and fills from bit 39. Opcode 12 shifts right and fills with zeros. Opcode 13 shifts left and fills with zeros. An amount of 40 or more gives all copies of the sign bit for opcode 11 and zero for opcodes 12 and 13.
- R9: Opcode 14 inverts accumulator bit sel_in when sel_in is below 40. A larger sel_in leaves the accumulator unchanged.
- R10: Opcode 15 checks whether bits 39..31 of the accumulator are all equal. If they are not, the accumulator becomes 0x007FFFFFFF when bit 39 is 0 and 0xFF80000000 when bit 39 is 1. Otherwise it is left unchanged.
- R11: Inputs are ignored, and no register changes, while op_valid is low or the opcode is 0. Multiplier opcodes (1..4) leave the accumulator unchanged. Accumulator opcodes (5..15) leave X, Y and the product unchanged.
- R12: The result of an operation accepted on a rising clock edge shows on the outputs right after that edge, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code, values listed in the requirements |
| opnd_a | input | 16 | Q15 operand for X, or for Y when opcode 2 is used |
| opnd_b | input | 16 | Q15 operand for Y in the paired writes |
| wide_in | input | 32 | 32-bit signed operand for the accumulator |
| sel_in | input | 6 | Shift amount or bit index |
| x_q | output | 16 | X operand register |
| y_q | output | 16 | Y operand register |
| prod_q | output | 32 | Product register, high and low halves |
| acc_q | output | 40 | Accumulator: guard bits, high and low words |

## Verification
Every result of this block is due exactly one clock edge after its operation is accepted. This covers the operand registers, the product (including the saturated MAC sum) and every accumulator operation. The driver applies an operation on a falling edge and queues the full expected register state. The monitor takes that entry off the queue half a high phase after the next rising edge, and it compares all four registers there. The monitor therefore always samples one edge after the stimulus. A result that came a cycle late or early would be compared against the wrong queued state and would show up as a mismatch.

// File: rtl/qmac_pkg.sv
package qmac_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDX   = 4'd1,
    OP_LDY   = 4'd2,
    OP_LDXY  = 4'd3,
    OP_MACXY = 4'd4,
    OP_ADDP  = 4'd5,
    OP_SUBP  = 4'd6,
    OP_ADDW  = 4'd7,
    OP_SUBW  = 4'd8,
    OP_MOVP  = 4'd9,
    OP_MOVW  = 4'd10,
    OP_ASR   = 4'd11,
    OP_LSR   = 4'd12,
    OP_ASL   = 4'd13,
    OP_TGL   = 4'd14,
    OP_LIM   = 4'd15
  } qmac_op_e;

  typedef struct packed {
    logic load_x;
    logic load_y;
    logic y_from_a;
    logic accumulate;
  } qmac_mul_ctl_t;

endpackage

// File: rtl/qmac_mult.sv
module qmac_mult #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   x_nxt,
  input  logic [DW-1:0]   y_nxt,
  input  logic [2*DW-1:0] prev_prod,
  input  logic            accumulate,
  output logic [2*DW-1:0] prod_nxt,
  output logic            corner
);
  localparam int PW = 2 * DW;
  localparam logic [DW-1:0] MIN_OP  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [PW-1:0] MAX_P   = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] MIN_P   = {1'b1, {(PW-1){1'b0}}};

  // Fractional multiply: full signed product doubled, -1*-1 pinned to max.
  function automatic logic [PW-1:0] frac_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    logic signed [PW-1:0] full;
    ea   = PW'($signed(a));
    eb   = PW'($signed(b));
    full = ea * eb;
    if (a == MIN_OP && b == MIN_OP) return MAX_P;
    return full <<< 1;
  endfunction

  // Saturating 32-bit addition of two signed products.
  function automatic logic [PW-1:0] sat_add(input logic [PW-1:0] p, input logic [PW-1:0] q);
    logic [PW:0] s;
    s = {p[PW-1], p} + {q[PW-1], q};
    if (s[PW] != s[PW-1]) return s[PW] ? MIN_P : MAX_P;
    return s[PW-1:0];
  endfunction

  logic [PW-1:0] fresh;

  always_comb begin
    fresh    = frac_mul(x_nxt, y_nxt);
    prod_nxt = accumulate ? sat_add(prev_prod, fresh) : fresh;
    corner   = (x_nxt == MIN_OP) && (y_nxt == MIN_OP);
  end

endmodule

// File: rtl/qmac_alu.sv
module qmac_alu
  import qmac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  parameter int SELW  = 6
) (
  input  qmac_op_e                 op,
  input  logic                     op_valid,
  input  logic [2*DW+GUARD-1:0]    acc,
  input  logic [2*DW-1:0]          prod,
  input  logic [2*DW-1:0]          wide,
  input  logic [SELW-1:0]          sel,
  output logic [2*DW+GUARD-1:0]    acc_nxt,
  output logic                     acc_we,
  output logic                     limit_hit
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GUARD;

  function automatic logic [AW-1:0] widen(input logic [PW-1:0] v);
    return AW'($signed(v));
  endfunction

  logic [AW-1:0] lim_val;

  generate
    if (GUARD > 0) begin : g_limit
      localparam logic [AW-1:0] MAX_A = AW'({1'b0, {(PW-1){1'b1}}});
      localparam logic [AW-1:0] MIN_A = ~MAX_A;
      logic [GUARD:0] top_bits;
      logic           in_range;
      always_comb begin
        top_bits  = acc[AW-1:PW-1];
        in_range  = (&top_bits) | ~(|top_bits);
        limit_hit = !in_range;
        lim_val   = in_range ? acc : (acc[AW-1] ? MIN_A : MAX_A);
      end
    end else begin : g_nolimit
      always_comb begin
        limit_hit = 1'b0;
        lim_val   = acc;
      end
    end
  endgenerate

  always_comb begin
    acc_nxt = acc;
    acc_we  = op_valid;
    unique case (op)
      OP_ADDP: acc_nxt = acc + widen(prod);
      OP_SUBP: acc_nxt = acc - widen(prod);
      OP_ADDW: acc_nxt = acc + widen(wide);
      OP_SUBW: acc_nxt = acc - widen(wide);
      OP_MOVP: acc_nxt = widen(prod);
      OP_MOVW: acc_nxt = widen(wide);
      OP_ASR:  acc_nxt = $signed(acc) >>> sel;
      OP_LSR:  acc_nxt = acc >> sel;
      OP_ASL:  acc_nxt = acc << sel;
      OP_TGL:  acc_nxt = (int'(sel) < AW) ? (acc ^ (AW'(1) << sel)) : acc;
      OP_LIM:  acc_nxt = lim_val;
      default: acc_we  = 1'b0;
    endcase
  end

endmodule

// File: rtl/qmac_unit.sv
module qmac_unit
  import qmac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  parameter int SELW  = $clog2(2*DW+GUARD)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [3:0]             op_code,
  input  logic [DW-1:0]          opnd_a,
  input  logic [DW-1:0]          opnd_b,
  input  logic [2*DW-1:0]        wide_in,
  input  logic [SELW-1:0]        sel_in,
  output logic [DW-1:0]          x_q,
  output logic [DW-1:0]          y_q,
  output logic [2*DW-1:0]        prod_q,
  output logic [2*DW+GUARD-1:0]  acc_q
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GUARD;

  qmac_op_e      op;
  qmac_mul_ctl_t mctl;
  logic [DW-1:0] x_nxt;
  logic [DW-1:0] y_nxt;
  logic [PW-1:0] prod_nxt;
  logic [AW-1:0] acc_nxt;

  // Named internal events, visible to the bound checker.
  logic prod_we;
  logic acc_we;
  logic mul_corner;
  logic limit_hit;

  assign op = qmac_op_e'(op_code);

  always_comb begin
    mctl = '0;
    if (op_valid) begin
      unique case (op)
        OP_LDX:   mctl.load_x = 1'b1;
        OP_LDY:   begin mctl.load_y = 1'b1; mctl.y_from_a = 1'b1; end
        OP_LDXY:  begin mctl.load_x = 1'b1; mctl.load_y = 1'b1; end
        OP_MACXY: begin mctl.load_x = 1'b1; mctl.load_y = 1'b1; mctl.accumulate = 1'b1; end
        default:  mctl = '0;
      endcase
    end
    prod_we = mctl.load_x | mctl.load_y;
    x_nxt   = mctl.load_x ? opnd_a : x_q;
    y_nxt   = mctl.load_y ? (mctl.y_from_a ? opnd_a : opnd_b) : y_q;
  end

  qmac_mult #(.DW(DW)) u_mult (
    .x_nxt      (x_nxt),
    .y_nxt      (y_nxt),
    .prev_prod  (prod_q),
    .accumulate (mctl.accumulate),
    .prod_nxt   (prod_nxt),
    .corner     (mul_corner)
  );

  qmac_alu #(.DW(DW), .GUARD(GUARD), .SELW(SELW)) u_alu (
    .op        (op),
    .op_valid  (op_valid),
    .acc       (acc_q),
    .prod      (prod_q),
    .wide      (wide_in),
    .sel       (sel_in),
    .acc_nxt   (acc_nxt),
    .acc_we    (acc_we),
    .limit_hit (limit_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      if (mctl.load_x) x_q <= x_nxt;
      if (mctl.load_y) y_q <= y_nxt;
      if (prod_we)     prod_q <= prod_nxt;
      if (acc_we)      acc_q  <= acc_nxt;
    end
  end

endmodule

// File: rtl/qmac_chk.sv
module qmac_chk
  import qmac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  parameter int SELW  = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  op_valid,
  input logic [3:0]            op_code,
  input logic [SELW-1:0]       sel_in,
  input logic [DW-1:0]         x_q,
  input logic [DW-1:0]         y_q,
  input logic [2*DW-1:0]       prod_q,
  input logic [2*DW+GUARD-1:0] acc_q,
  input logic                  prod_we,
  input logic                  acc_we,
  input logic                  mul_corner,
  input logic                  limit_hit
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GUARD;
  localparam logic [PW-1:0] MAX_P = {1'b0, {(PW-1){1'b1}}};

  p_corner_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_we && mul_corner && op_code != OP_MACXY) |=> (prod_q == MAX_P));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(x_q) && $stable(y_q) && $stable(prod_q) && $stable(acc_q)));

  p_mul_keeps_acc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    prod_we |=> $stable(acc_q));

  p_acc_keeps_mul_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> ($stable(prod_q) && $stable(x_q) && $stable(y_q)));

  p_limit_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LIM) |=>
      ($countones(acc_q[AW-1:PW-1]) == 0 || $countones(acc_q[AW-1:PW-1]) == GUARD + 1));

  p_limit_hit_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LIM && limit_hit) |=> !$stable(acc_q));

  p_lsr_top_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LSR && sel_in != '0) |=> !acc_q[AW-1]);

  p_toggle_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_TGL && int'(sel_in) < AW) |=>
      ($countones(acc_q ^ $past(acc_q)) == 1));

endmodule

bind qmac_unit qmac_chk #(.DW(DW), .GUARD(GUARD), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .sel_in     (sel_in),
  .x_q        (x_q),
  .y_q        (y_q),
  .prod_q     (prod_q),
  .acc_q      (acc_q),
  .prod_we    (prod_we),
  .acc_we     (acc_we),
  .mul_corner (mul_corner),
  .limit_hit  (limit_hit)
);

// File: tb/qmac_unit_tb.sv
module qmac_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [31:0] wide_in = '0;
  logic [5:0]  sel_in = '0;
  logic [15:0] x_q;
  logic [15:0] y_q;
  logic [31:0] prod_q;
  logic [39:0] acc_q;

  always #10 clk = ~clk;  // 50 MHz

  qmac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .wide_in(wide_in), .sel_in(sel_in),
    .x_q(x_q), .y_q(y_q), .prod_q(prod_q), .acc_q(acc_q)
  );

  typedef struct {
    logic [15:0] x;
    logic [15:0] y;
    logic [31:0] p;
    logic [39:0] a;
    string       tag;
  } exp_t;

  exp_t   sb_q[$];
  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;

  // Reference model state as wide signed integers.
  longint mx = 0, my = 0, mp = 0, ma = 0;
  localparam longint M40 = (64'sd1 <<< 40) - 1;

  function automatic longint s16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint s32(input logic [31:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint q15_prod(input longint a, input longint b);
    longint r;
    r = 2 * a * b;
    if (r == 64'sd2147483648) r = 64'sd2147483647;
    return r;
  endfunction

  function automatic longint clamp32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint wrap40(input longint v);
    longint u;
    u = v & M40;
    if (u >= (64'sd1 <<< 39)) u = u - (64'sd1 <<< 40);
    return u;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1, 4'd2:              return "R4";
      4'd3:                    return "R2";
      4'd4:                    return "R5";
      4'd5, 4'd6:              return "R6";
      4'd7, 4'd8, 4'd9, 4'd10: return "R7";
      4'd11, 4'd12, 4'd13:     return "R8";
      4'd14:                   return "R9";
      4'd15:                   return "R10";
      default:                 return "R11";
    endcase
  endfunction

  // Driver: applies one operation at a falling edge and queues the expected state.
  task automatic issue(input bit v, input logic [3:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [31:0] w, input logic [5:0] s,
                       input string t = "");
    exp_t   e;
    longint u;
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b; wide_in = w; sel_in = s;
    if (v) begin
      case (op)
        4'd1:  begin mx = s16(a); mp = q15_prod(mx, my); end
        4'd2:  begin my = s16(a); mp = q15_prod(mx, my); end
        4'd3:  begin mx = s16(a); my = s16(b); mp = q15_prod(mx, my); end
        4'd4:  begin mx = s16(a); my = s16(b); mp = clamp32(mp + q15_prod(mx, my)); end
        4'd5:  ma = wrap40(ma + mp);
        4'd6:  ma = wrap40(ma - mp);
        4'd7:  ma = wrap40(ma + s32(w));
        4'd8:  ma = wrap40(ma - s32(w));
        4'd9:  ma = mp;
        4'd10: ma = s32(w);
        4'd11: ma = (s >= 40) ? ((ma < 0) ? -64'sd1 : 64'sd0) : (ma >>> s);
        4'd12: begin u = ma & M40; ma = (s >= 40) ? 64'sd0 : wrap40(u >> s); end
        4'd13: ma = (s >= 40) ? 64'sd0 : wrap40(ma << s);
        4'd14: if (s < 40) ma = wrap40((ma & M40) ^ (64'sd1 <<< s));
        4'd15: ma = clamp32(ma);
        default: ;
      endcase
    end
    e.x = mx[15:0]; e.y = my[15:0]; e.p = mp[31:0]; e.a = ma[39:0];
    e.tag = (t != "") ? t : (v ? tag_of(op) : "R11");
    sb_q.push_back(e);
  endtask

  // Monitor: one edge after each operation (R12), compare the full register state.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_chk++;
        if (x_q !== e.x || y_q !== e.y || prod_q !== e.p || acc_q !== e.a) begin
          n_bad++;
          $display("FAIL %s (R12 timing): got x=%h y=%h p=%h a=%h, expected x=%h y=%h p=%h a=%h",
                   e.tag, x_q, y_q, prod_q, acc_q, e.x, e.y, e.p, e.a);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    lf = 32'hACE1_2468;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (x_q !== '0 || y_q !== '0 || prod_q !== '0 || acc_q !== '0) begin
      n_bad++;
      $display("FAIL R1: got x=%h y=%h p=%h a=%h, expected all zero", x_q, y_q, prod_q, acc_q);
    end
    rst_n = 1'b1;

    // R4: single-register writes use the held partner.
    issue(1, 4'd1, 16'h4000, 16'h1111, 32'h0, 6'd0);
    issue(1, 4'd2, 16'h4000, 16'h2222, 32'h0, 6'd0);
    issue(1, 4'd1, 16'hC000, 16'h0, 32'h0, 6'd0);
    // R3: -1 x -1 saturates.
    issue(1, 4'd3, 16'h8000, 16'h8000, 32'h0, 6'd0, "R3");
    issue(1, 4'd2, 16'h8000, 16'h0, 32'h0, 6'd0);
    issue(1, 4'd1, 16'h8000, 16'h0, 32'h0, 6'd0, "R3");
    // R2: paired writes.
    issue(1, 4'd3, 16'h8000, 16'h7FFF, 32'h0, 6'd0);
    issue(1, 4'd3, 16'h7FFF, 16'h7FFF, 32'h0, 6'd0);
    issue(1, 4'd3, 16'hFFFF, 16'h0001, 32'h0, 6'd0);
    // R5: MAC with positive and negative saturation.
    issue(1, 4'd3, 16'h4000, 16'h4000, 32'h0, 6'd0);
    issue(1, 4'd4, 16'h7FFF, 16'h7FFF, 32'h0, 6'd0);
    issue(1, 4'd4, 16'h8000, 16'h7FFF, 32'h0, 6'd0);
    issue(1, 4'd4, 16'h8000, 16'h7FFF, 32'h0, 6'd0);
    issue(1, 4'd4, 16'h8000, 16'h7FFF, 32'h0, 6'd0);
    issue(1, 4'd4, 16'h8000, 16'h8000, 32'h0, 6'd0);
    // R6/R10: overflow into guard bits then limit.
    issue(1, 4'd3, 16'h8000, 16'h8000, 32'h0, 6'd0, "R3");
    issue(1, 4'd10, 16'h0, 16'h0, 32'h0, 6'd0);
    for (int i = 0; i < 5; i++) issue(1, 4'd5, 16'h0, 16'h0, 32'h0, 6'd0);
    issue(1, 4'd15, 16'h0, 16'h0, 32'h0, 6'd0);
    issue(1, 4'd15, 16'h0, 16'h0, 32'h0, 6'd0);
    for (int i = 0; i < 8; i++) issue(1, 4'd6, 16'h0, 16'h0, 32'h0, 6'd0);
    issue(1, 4'd15, 16'h0, 16'h0, 32'h0, 6'd0);
    // R7: wide operand and moves.
    issue(1, 4'd10, 16'h0, 16'h0, 32'h8000_0000, 6'd0);
    issue(1, 4'd8, 16'h0, 16'h0, 32'h7FFF_FFFF, 6'd0);
    issue(1, 4'd7, 16'h0, 16'h0, 32'h1234_5678, 6'd0);
    issue(1, 4'd9, 16'h0, 16'h0, 32'h0, 6'd0);
    // R8: shifts, including amounts of 40 or more.
    issue(1, 4'd10, 16'h0, 16'h0, 32'h8000_0010, 6'd0);
    issue(1, 4'd11, 16'h0, 16'h0, 32'h0, 6'd4);
    issue(1, 4'd12, 16'h0, 16'h0, 32'h0, 6'd4);
    issue(1, 4'd13, 16'h0, 16'h0, 32'h0, 6'd8);
    issue(1, 4'd10, 16'h0, 16'h0, 32'hF000_0000, 6'd0);
    issue(1, 4'd11, 16'h0, 16'h0, 32'h0, 6'd45);
    issue(1, 4'd10, 16'h0, 16'h0, 32'hF000_0000, 6'd0);
    issue(1, 4'd12, 16'h0, 16'h0, 32'h0, 6'd40);
    issue(1, 4'd10, 16'h0, 16'h0, 32'h0000_0003, 6'd0);
    issue(1, 4'd13, 16'h0, 16'h0, 32'h0, 6'd40);
    // R9: toggle in and out of range.
    issue(1, 4'd14, 16'h0, 16'h0, 32'h0, 6'd39);
    issue(1, 4'd14, 16'h0, 16'h0, 32'h0, 6'd0);
    issue(1, 4'd14, 16'h0, 16'h0, 32'h0, 6'd45);
    issue(1, 4'd14, 16'h0, 16'h0, 32'h0, 6'd31);
    // R11: idle strobe and NOP ignore their data.
    issue(0, 4'd10, 16'h7777, 16'h5555, 32'hDEAD_BEEF, 6'd3);
    issue(0, 4'd3, 16'h1234, 16'h4321, 32'h0, 6'd0);
    issue(1, 4'd0, 16'h1234, 16'h4321, 32'hDEAD_BEEF, 6'd9);
    // Mixed pseudo-random traffic.
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(lf[31:28] != 4'd0, lf[3:0], lf[27:12], {lf[11:4], lf[31:24]},
            {lf[15:0], lf[31:16]}, lf[9:4]);
    end
    issue(1, 4'd0, 16'h0, 16'h0, 32'h0, 6'd0);
    while (sb_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule